// File: doc/BRIEF.md
# Video Sync Presence Detector

This block judges whether an external video synchronising signal is present. Once per horizontal line period a strobe arrives, together with a flag saying whether a horizontal sync pulse was seen during that line. The block counts consecutive lines with a pulse and consecutive lines without one. It then applies two separate programmable thresholds, a short one for acquiring sync and a long one for losing it. The result is a single presence status that does not chatter on isolated noisy lines.

The same status pin can carry two other signals. An odd/even field flag can be routed to it, or a line-range window signal can be. When the window mode is set, it takes priority over the field selection. Threshold codes are one-hot. A code with more than one bit set takes the threshold of its highest set bit.

Top module: `sync_presence_detector`

## Requirements
- R1: After reset the presence judgment is absent, both run counts are zero, and the status output is low when neither alternative source is selected.
- R2: While absent, the judgment becomes present on the line strobe at which the run of consecutive detected lines reaches the acquire threshold. The acquire code `acq_code` maps 000 = first detected line, 001 = 4, 010 = 8 and 100 = 16 lines.
- R3: While absent, a line strobe with no sync seen resets the detected-line run to zero.
- R4: While present, the judgment becomes absent on the line strobe at which the run of consecutive missed lines reaches the lose threshold. The lose code `lose_code` maps 0001 = 32, 0010 = 64, 0100 = 128 and 1000 = 256 lines.
- R5: When `lose_code` is 0000, loss detection is disabled and the judgment stays present through any number of missed lines.
- R6: While present, a line strobe with sync seen resets the missed-line run to zero.
- R7: A threshold code with several bits set uses the threshold of its highest set bit (for example acquire 011 = 8, acquire 110 = 16, lose 0011 = 64).
- R8: The judgment and the run counts change only on clock edges where `line_strobe` is high.
- R9: `status` equals `range_window` when `range_mode` is 1. Otherwise it equals `field_odd` when `field_sel` is 1. Otherwise it equals the presence judgment.
- R10: Changes of `sync_hit` while `line_strobe` is low have no effect on the judgment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | One-cycle pulse once per horizontal line |
| sync_hit | input | 1 | Horizontal sync pulse seen during the line just ended |
| acq_code | input | 3 | One-hot acquire threshold code |
| lose_code | input | 4 | One-hot lose threshold code, 0 disables loss |
| field_sel | input | 1 | Route the field flag to `status` |
| field_odd | input | 1 | Odd/even field flag |
| range_mode | input | 1 | Route the line-range window to `status` (highest priority) |
| range_window | input | 1 | Window active over the configured line range |
| status | output | 1 | Presence judgment or selected alternative |

## Verification
Stimulus is built from runs of detected and missed lines that stop one line short of each threshold and then one line past it. This separates an off-by-one count from a correct one for every listed code. Runs broken by a single opposite line show whether each counter is cleared by the opposite event, and not only by a state change. Multi-bit codes and the all-zero lose code show the priority decode and the disable. Toggling `sync_hit` between strobes, with gaps of several idle cycles, shows that only strobed lines count. Walking the three select inputs through their combinations shows the priority of the output sources.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   typedef enum logic [1:0] {
      SRC_PRESENCE = 2'd0,
      SRC_FIELD    = 2'd1,
      SRC_WINDOW   = 2'd2
   } sdp_src_e;

   function automatic sdp_src_e pick_source(input logic range_mode, input logic field_sel);
      if (range_mode)     return SRC_WINDOW;
      else if (field_sel) return SRC_FIELD;
      else                return SRC_PRESENCE;
   endfunction
endpackage

// File: rtl/sdp_thresh_decode.sv
// Priority decode of a one-hot threshold code: the highest set bit wins,
// giving BASE << bit_index; an all-zero code yields limit 0, enabled 0.
module sdp_thresh_decode #(
   parameter int CODE_W = 3,
   parameter int BASE   = 4,
   parameter int VAL_W  = 5
) (
   input  logic [CODE_W-1:0] code,
   output logic [VAL_W-1:0]  limit,
   output logic              enabled
);
   logic [VAL_W-1:0] chain [CODE_W+1];

   assign chain[0] = '0;

   generate
      for (genvar i = 0; i < CODE_W; i++) begin : g_stage
         localparam logic [VAL_W-1:0] STEP_VAL = VAL_W'(BASE << i);
         assign chain[i+1] = code[i] ? STEP_VAL : chain[i];
      end
   endgenerate

   assign limit   = chain[CODE_W];
   assign enabled = |code;
endmodule

// File: rtl/sdp_run_counter.sv
// Counts consecutive qualifying line strobes; flags the strobe on which
// the run reaches the limit and restarts from zero.
module sdp_run_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             count_en,
   input  logic             clear,
   input  logic [CNT_W-1:0] limit,
   output logic             reached
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   next_run;

   assign next_run = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign reached  = strobe & count_en & ~clear & (next_run >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (strobe) begin
         if (clear || reached) cnt_q <= '0;
         else if (count_en)    cnt_q <= next_run[CNT_W-1:0];
      end
   end

   // R3 / R6: an opposite-polarity line empties the run
   p_clear_empties_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && clear) |=> (cnt_q == '0));

   // R8: the run only moves on a strobe
   p_run_holds_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(cnt_q));
endmodule

// File: rtl/sdp_status_sel.sv
module sdp_status_sel #(
   parameter bit ALT_SOURCES = 1'b1
) (
   input  logic present,
   input  logic field_sel,
   input  logic field_odd,
   input  logic range_mode,
   input  logic range_window,
   output logic status
);
   import sdp_pkg::*;

   generate
      if (ALT_SOURCES) begin : g_mux
         sdp_src_e src;
         always_comb begin
            src = pick_source(range_mode, field_sel);
            unique case (src)
               SRC_WINDOW: status = range_window;
               SRC_FIELD:  status = field_odd;
               default:    status = present;
            endcase
         end
      end else begin : g_direct
         logic unused_alt;
         assign unused_alt = field_sel ^ field_odd ^ range_mode ^ range_window;
         assign status     = present;
      end
   endgenerate
endmodule

// File: rtl/sync_presence_detector.sv
module sync_presence_detector #(
   parameter int ACQ_CODE_W  = 3,
   parameter int ACQ_BASE    = 4,
   parameter int LOSE_CODE_W = 4,
   parameter int LOSE_BASE   = 32,
   parameter bit ALT_SOURCES = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   line_strobe,
   input  logic                   sync_hit,
   input  logic [ACQ_CODE_W-1:0]  acq_code,
   input  logic [LOSE_CODE_W-1:0] lose_code,
   input  logic                   field_sel,
   input  logic                   field_odd,
   input  logic                   range_mode,
   input  logic                   range_window,
   output logic                   status
);
   localparam int ACQ_MAX  = ACQ_BASE << (ACQ_CODE_W - 1);
   localparam int LOSE_MAX = LOSE_BASE << (LOSE_CODE_W - 1);
   localparam int ACQ_W    = $clog2(ACQ_MAX + 1);
   localparam int LOSE_W   = $clog2(LOSE_MAX + 1);

   generate
      if (ACQ_CODE_W < 1 || LOSE_CODE_W < 1) begin : g_bad_code
         $error("threshold code widths must be at least 1");
      end
      if (ACQ_BASE < 1 || LOSE_BASE < 1) begin : g_bad_base
         $error("threshold bases must be positive");
      end
      if (ACQ_W > 30 || LOSE_W > 30) begin : g_bad_span
         $error("threshold range too wide");
      end
   endgenerate

   logic [ACQ_W-1:0]  acq_limit;
   logic [LOSE_W-1:0] lose_limit;
   logic              acq_nonzero;
   logic              lose_en;
   logic              present_q;
   logic              acq_hit, lose_hit;

   sdp_thresh_decode #(.CODE_W(ACQ_CODE_W), .BASE(ACQ_BASE), .VAL_W(ACQ_W)) u_acq_dec (
      .code(acq_code), .limit(acq_limit), .enabled(acq_nonzero));

   sdp_thresh_decode #(.CODE_W(LOSE_CODE_W), .BASE(LOSE_BASE), .VAL_W(LOSE_W)) u_lose_dec (
      .code(lose_code), .limit(lose_limit), .enabled(lose_en));

   // detected-line run, active only while absent
   sdp_run_counter #(.CNT_W(ACQ_W)) u_hit_run (
      .clk(clk), .rst_n(rst_n), .strobe(line_strobe),
      .count_en(sync_hit & ~present_q),
      .clear(~sync_hit | present_q),
      .limit(acq_limit), .reached(acq_hit));

   // missed-line run, active only while present and loss detection enabled
   sdp_run_counter #(.CNT_W(LOSE_W)) u_miss_run (
      .clk(clk), .rst_n(rst_n), .strobe(line_strobe),
      .count_en(~sync_hit & present_q & lose_en),
      .clear(sync_hit | ~present_q | ~lose_en),
      .limit(lose_limit), .reached(lose_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        present_q <= 1'b0;
      else if (acq_hit)  present_q <= 1'b1;
      else if (lose_hit) present_q <= 1'b0;
   end

   sdp_status_sel #(.ALT_SOURCES(ALT_SOURCES)) u_sel (
      .present(present_q), .field_sel(field_sel), .field_odd(field_odd),
      .range_mode(range_mode), .range_window(range_window), .status(status));

   logic unused_acq_flag;
   assign unused_acq_flag = acq_nonzero;

   p_judgment_strobed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !line_strobe |=> $stable(present_q));

   p_acquire_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(present_q) |-> $past(line_strobe && sync_hit));

   p_lose_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(present_q) |-> $past(line_strobe && !sync_hit));

   p_no_loss_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(present_q) |-> $past(lose_code != '0));

   p_window_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
      range_mode |-> (status == range_window));
endmodule

// File: tb/sync_presence_detector_bench.sv
module sync_presence_detector_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_strobe = 1'b0;
   logic       sync_hit = 1'b0;
   logic [2:0] acq_code = 3'b001;
   logic [3:0] lose_code = 4'b0001;
   logic       field_sel = 1'b0;
   logic       field_odd = 1'b0;
   logic       range_mode = 1'b0;
   logic       range_window = 1'b0;
   logic       status;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference model state
   int  m_hits = 0;
   int  m_miss = 0;
   bit  m_present = 1'b0;

   always #10 clk = ~clk;

   sync_presence_detector u_sync_presence_detector (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .sync_hit(sync_hit),
      .acq_code(acq_code), .lose_code(lose_code), .field_sel(field_sel),
      .field_odd(field_odd), .range_mode(range_mode), .range_window(range_window),
      .status(status));

   function automatic int acq_need(input logic [2:0] c);
      if (c[2])      return 16;
      else if (c[1]) return 8;
      else if (c[0]) return 4;
      else           return 1;
   endfunction

   function automatic int lose_need(input logic [3:0] c);
      if (c[3])      return 256;
      else if (c[2]) return 128;
      else if (c[1]) return 64;
      else if (c[0]) return 32;
      else           return 0;
   endfunction

   function automatic bit model_status();
      if (range_mode)     return range_window;
      else if (field_sel) return field_odd;
      else                return m_present;
   endfunction

   task automatic check(input bit actual, input bit expected, input string req);
      tests++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s: status=%0b expected=%0b at %0t", req, actual, expected, $time);
      end
   endtask

   // cycle model, compared 5 ns after each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_hits = 0; m_miss = 0; m_present = 1'b0;
      end else if (line_strobe) begin
         if (sync_hit) begin
            m_miss = 0;
            if (!m_present) begin
               m_hits++;
               if (m_hits >= acq_need(acq_code)) begin m_present = 1'b1; m_hits = 0; end
            end
         end else begin
            m_hits = 0;
            if (m_present && lose_need(lose_code) != 0) begin
               m_miss++;
               if (m_miss >= lose_need(lose_code)) begin m_present = 1'b0; m_miss = 0; end
            end else m_miss = 0;
         end
      end
      #5;
      if (rst_n && !done) check(status, model_status(), "R8 per-cycle model (R10 noise)");
   end

   // one line: strobe with hit, then noise of opposite polarity between strobes
   task automatic line(input bit hit);
      @(negedge clk); line_strobe = 1'b1; sync_hit = hit;
      @(negedge clk); line_strobe = 1'b0; sync_hit = ~hit;
      @(negedge clk); sync_hit = hit;
   endtask

   task automatic lines(input bit hit, input int n);
      for (int i = 0; i < n; i++) line(hit);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(status, 1'b0, "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check(status, 1'b0, "R1 after reset release");

      // R2: code 001 -> 4 lines
      acq_code = 3'b001; lose_code = 4'b0001;
      lines(1'b1, 3);  check(status, 1'b0, "R2 3 of 4 hits");
      line(1'b1);      check(status, 1'b1, "R2 4th hit acquires");

      // R4: 0001 -> 32 misses
      lines(1'b0, 31); check(status, 1'b1, "R4 31 of 32 misses");
      line(1'b0);      check(status, 1'b0, "R4 32nd miss loses");

      // R3: code 010 -> 8; broken run
      acq_code = 3'b010;
      lines(1'b1, 7); line(1'b0); lines(1'b1, 7);
      check(status, 1'b0, "R3 miss restarts hit run");
      line(1'b1);      check(status, 1'b1, "R3 R2 8th consecutive hit acquires");

      // R6: broken miss run
      lines(1'b0, 31); line(1'b1); lines(1'b0, 31);
      check(status, 1'b1, "R6 hit restarts miss run");
      line(1'b0);      check(status, 1'b0, "R6 32nd consecutive miss loses");

      // R2: code 000 -> first hit
      acq_code = 3'b000;
      line(1'b0);      check(status, 1'b0, "R2 code 000 miss does not acquire");
      line(1'b1);      check(status, 1'b1, "R2 code 000 first hit acquires");

      // R5: disabled loss
      lose_code = 4'b0000;
      lines(1'b0, 300); check(status, 1'b1, "R5 loss disabled");

      // R7: lose 0011 -> 64
      lose_code = 4'b0011;
      lines(1'b0, 63); check(status, 1'b1, "R7 lose 0011 63 misses");
      line(1'b0);      check(status, 1'b0, "R7 lose 0011 64th miss");

      // R7: acq 011 -> 8
      acq_code = 3'b011;
      lines(1'b1, 7);  check(status, 1'b0, "R7 acq 011 7 hits");
      line(1'b1);      check(status, 1'b1, "R7 acq 011 8th hit");

      // R4: 1000 -> 256
      lose_code = 4'b1000;
      lines(1'b0, 255); check(status, 1'b1, "R4 255 of 256 misses");
      line(1'b0);       check(status, 1'b0, "R4 256th miss loses");

      // R7: acq 110 -> 16, R2 code 100 -> 16
      acq_code = 3'b110;
      lines(1'b1, 15); check(status, 1'b0, "R7 acq 110 15 hits");
      line(1'b1);      check(status, 1'b1, "R7 acq 110 16th hit");
      lose_code = 4'b0100;
      lines(1'b0, 127); check(status, 1'b1, "R4 127 of 128 misses");
      line(1'b0);       check(status, 1'b0, "R4 128th miss loses");
      acq_code = 3'b100;
      lines(1'b1, 15); check(status, 1'b0, "R2 code 100 15 hits");
      line(1'b1);      check(status, 1'b1, "R2 code 100 16th hit");

      // R10: sync_hit toggles with no strobe for many cycles
      lose_code = 4'b0001;
      for (int i = 0; i < 40; i++) begin @(negedge clk); sync_hit = i[0]; end
      check(status, 1'b1, "R10 unstrobed sync_hit ignored");
      lines(1'b0, 32); check(status, 1'b0, "R10 R4 loss counts strobes only");

      // R9: source priority (judgment is now absent)
      field_sel = 1'b1; field_odd = 1'b1; #1;
      check(status, 1'b1, "R9 field flag routed");
      field_odd = 1'b0; #1;
      check(status, 1'b0, "R9 field flag low");
      range_mode = 1'b1; range_window = 1'b1; field_odd = 1'b0; #1;
      check(status, 1'b1, "R9 window overrides field");
      range_window = 1'b0; field_odd = 1'b1; #1;
      check(status, 1'b0, "R9 window low overrides field high");
      range_mode = 1'b0; field_sel = 1'b0; #1;
      check(status, 1'b0, "R9 back to judgment");

      // R1: reset clears a partial run
      acq_code = 3'b001;
      lines(1'b1, 3); do_reset();
      check(status, 1'b0, "R1 reset state absent");
      lines(1'b1, 3); check(status, 1'b0, "R1 run restarted after reset");
      line(1'b1);     check(status, 1'b1, "R1 R2 acquire after reset");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule